// File: doc/BRIEF.md
# SMBus Alert Response Handler

This block sits beside the byte-level protocol engine of an SMBus client and looks after the alert line. An internal error flag pulls the open-drain alert output low unless a mask bit is set. A host that sees the alert broadcasts a read to the Alert Response Address. The block recognises that address, acknowledges it, and sends its own slave address back onto SDA. It watches the line on every bit so that it can tell whether another alerting device has won arbitration. Only a reply that went out complete and unbeaten sets the mask and releases the alert. A register-write strobe from the register file clears the mask again.

The block also decodes the three-level address-select pin into the client's 7-bit slave address, which it hands to the protocol engine. It runs an idle watchdog from a slow timebase tick: when SCL and SDA stay quiet for too long, it drops any transaction in progress and pulses a reset toward the protocol engine. Separate over-temperature outputs follow their condition inputs directly, and alert handling never touches them. SCL and SDA arrive as already-synchronised samples. The SDA output is a pull-down enable.

Top module: `smb_alert_top`

## Requirements
- R1: `alertN` is low exactly while `errFlag` is high and the mask bit is clear; the mask bit is clear after reset.
- R2: The alert response address byte is 0x19 (address 0001100, read bit 1). The block pulls SDA low for the ninth clock of that byte only when `alertN` is low at the end of the eighth clock.
- R3: After acknowledging, the block sends the byte {`ownAddr`, 0} most significant bit first. It pulls SDA low for each 0 bit, starting after the ninth SCL falling edge, and releases SDA after the eighth reply bit.
- R4: If the block releases SDA for a 1 bit but samples SDA low on the SCL rising edge, it has lost arbitration. It drives nothing for the rest of that byte, and the mask stays unchanged.
- R5: A reply whose eight bits all went out without losing arbitration sets the mask, so `alertN` goes high. A pulse on `maskClr` clears the mask and takes priority over a set in the same cycle.
- R6: `addrSel` selects `ownAddr`: 2'b00 (pin low) gives 0x2F, 2'b01 (pin open) gives 0x2F, 2'b10 (pin high) gives 0x2E, and 2'b11 is treated as open.
- R7: A transaction whose first byte is not 0x19, or an alert response read while `alertN` is high, never causes SDA to be pulled low and leaves the mask unchanged.
- R8: `overTempN[i]` is the inverse of `overTempIn[i]`, one clock later, whatever happens on the bus.
- R9: After TIMEOUT_TICKS `tick` pulses with no SCL or SDA edge, `busReset` pulses for one cycle and SDA is released. The transaction in progress is dropped, so further clocks are ignored until a new START. Each idle period gives a single pulse.
- R10: A START (SDA falling while SCL is high), including a repeated START in the middle of a byte, restarts address reception. A STOP (SDA rising while SCL is high) returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised SCL sample |
| sdaIn | input | 1 | Synchronised SDA sample (resolved bus level) |
| errFlag | input | 1 | Internal error condition requesting an alert |
| addrSel | input | 2 | Decoded address-select pin level |
| tick | input | 1 | Timebase pulse for the idle watchdog |
| maskClr | input | 1 | Register-write strobe clearing the mask bit |
| overTempIn | input | OT_COUNT | Over-temperature conditions |
| alertN | output | 1 | Alert output, low = pull the open-drain line |
| sdaPullDown | output | 1 | High = pull SDA low |
| busReset | output | 1 | One-cycle idle-timeout reset toward the protocol engine |
| ownAddr | output | 7 | Decoded slave address |
| overTempN | output | OT_COUNT | Over-temperature outputs, low = active |

## Verification
The bench puts a second, competing device on SDA, so the wired-AND level decides every reply bit. A handler that kept driving after losing arbitration would corrupt the competitor's low-order bits. One that set the mask after losing would release the alert while its own event is still unanswered. Random addresses, error states and mask clears check that no foreign byte and no response while the alert is masked or idle ever draws an acknowledge. A stall in the middle of a byte must give one reset pulse and leave the rest of the byte without an acknowledge; a handler without the watchdog would still acknowledge. A repeated START after a few stray bits must still lead to a clean reply, which catches a bit counter that does not restart.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_REPLY,
    ST_SKIP
  } busStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftRx;
    logic driveAck;
    logic startReply;
    logic sampleArb;
    logic stepReply;
    logic finishReply;
    logic releaseSda;
  } strobeT;

  // conditions from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic byteDone;
    logic araHit;
    logic alertActive;
    logic idleHit;
  } busFlagsT;

endpackage

// File: rtl/smb_alert_dp.sv
module smb_alert_dp
  import smb_alert_pkg::*;
#(
  parameter int          TIMEOUT_TICKS = 30,
  parameter int          OT_COUNT      = 3,
  parameter logic [6:0]  ADDR_LOW      = 7'h2F,
  parameter logic [6:0]  ADDR_OPEN     = 7'h2F,
  parameter logic [6:0]  ADDR_HIGH     = 7'h2E,
  parameter logic [6:0]  ARA_ADDR      = 7'h0C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic                errFlag,
  input  logic [1:0]          addrSel,
  input  logic                tick,
  input  logic                maskClr,
  input  logic [OT_COUNT-1:0] overTempIn,
  input  strobeT              cmd,
  output busFlagsT            flags,
  output logic                sdaDrive,
  output logic                alertN,
  output logic                maskOn,
  output logic                busReset,
  output logic [6:0]          ownAddr,
  output logic [OT_COUNT-1:0] overTempN
);

  localparam int              CNT_W      = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] IDLE_LIMIT = CNT_W'(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] IDLE_LAST  = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
  localparam logic [7:0]       ARA_BYTE   = {ARA_ADDR, 1'b1};
  localparam logic [3:0]       BYTE_BITS  = 4'd8;

  logic             sclQ, sdaQ;
  logic             anyEdge;
  logic [CNT_W-1:0] idleCnt;
  logic             idleHitQ;
  logic [7:0]       rxByte;
  logic [6:0]       txBits;
  logic [3:0]       bitCnt;
  logic             lost;
  logic             driveQ;
  logic             maskQ;

  // previous line samples for edge and condition detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign anyEdge = (sclIn ^ sclQ) | (sdaIn ^ sdaQ);

  // address-select decode
  always_comb begin
    case (addrSel)
      2'b00:   ownAddr = ADDR_LOW;
      2'b10:   ownAddr = ADDR_HIGH;
      default: ownAddr = ADDR_OPEN;
    endcase
  end

  // idle watchdog, saturating so one pulse per quiet period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt  <= '0;
      idleHitQ <= 1'b0;
    end else begin
      idleHitQ <= 1'b0;
      if (anyEdge) begin
        idleCnt <= '0;
      end else if (tick && idleCnt != IDLE_LIMIT) begin
        idleCnt <= idleCnt + CNT_ONE;
        if (idleCnt == IDLE_LAST) idleHitQ <= 1'b1;
      end
    end
  end

  // bit shifting, reply drive, arbitration tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte <= '0;
      txBits <= '0;
      bitCnt <= '0;
      lost   <= 1'b0;
      driveQ <= 1'b0;
    end else begin
      if (cmd.clrCnt) begin
        bitCnt <= '0;
        lost   <= 1'b0;
      end
      if (cmd.shiftRx) begin
        rxByte <= {rxByte[6:0], sdaIn};
        bitCnt <= bitCnt + 4'd1;
      end
      if (cmd.driveAck) driveQ <= 1'b1;
      if (cmd.startReply) begin
        txBits <= {ownAddr[5:0], 1'b0};
        bitCnt <= '0;
        lost   <= 1'b0;
        driveQ <= ~ownAddr[6];
      end
      if (cmd.sampleArb) begin
        bitCnt <= bitCnt + 4'd1;
        if (!lost && !driveQ && !sdaIn) lost <= 1'b1;
      end
      if (cmd.stepReply) begin
        txBits <= {txBits[5:0], 1'b0};
        driveQ <= ~lost & ~txBits[6];
      end
      if (cmd.finishReply || cmd.releaseSda) driveQ <= 1'b0;
    end
  end

  // mask bit: clear strobe wins over a set in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)                            maskQ <= 1'b0;
    else if (maskClr)                     maskQ <= 1'b0;
    else if (cmd.finishReply && !lost)    maskQ <= 1'b1;
  end

  // over-temperature outputs, independent of the bus logic
  always_ff @(posedge clk) begin
    if (!rstN) overTempN <= '1;
    else       overTempN <= ~overTempIn;
  end

  assign flags.sclRise     = sclIn & ~sclQ;
  assign flags.sclFall     = ~sclIn & sclQ;
  assign flags.startSeen   = sclIn & sclQ & sdaQ & ~sdaIn;
  assign flags.stopSeen    = sclIn & sclQ & ~sdaQ & sdaIn;
  assign flags.byteDone    = (bitCnt == BYTE_BITS);
  assign flags.araHit      = (rxByte == ARA_BYTE);
  assign flags.alertActive = errFlag & ~maskQ;
  assign flags.idleHit     = idleHitQ;

  assign sdaDrive = driveQ;
  assign alertN   = ~(errFlag & ~maskQ);
  assign maskOn   = maskQ;
  assign busReset = idleHitQ;

endmodule

// File: rtl/smb_alert_ctl.sv
module smb_alert_ctl
  import smb_alert_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  busFlagsT flags,
  output strobeT   cmd,
  output busStateT busState
);

  busStateT nextState;

  always_comb begin
    cmd       = '0;
    nextState = busState;
    if (flags.idleHit) begin
      cmd.releaseSda = 1'b1;
      nextState      = ST_IDLE;
    end else if (flags.startSeen) begin
      cmd.clrCnt     = 1'b1;
      cmd.releaseSda = 1'b1;
      nextState      = ST_ADDR;
    end else if (flags.stopSeen) begin
      cmd.releaseSda = 1'b1;
      nextState      = ST_IDLE;
    end else begin
      case (busState)
        ST_ADDR: begin
          if (flags.sclRise) begin
            cmd.shiftRx = 1'b1;
          end else if (flags.sclFall && flags.byteDone) begin
            if (flags.araHit && flags.alertActive) begin
              cmd.driveAck = 1'b1;
              nextState    = ST_ACK;
            end else begin
              nextState = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (flags.sclFall) begin
            cmd.startReply = 1'b1;
            nextState      = ST_REPLY;
          end
        end
        ST_REPLY: begin
          if (flags.sclRise) begin
            cmd.sampleArb = 1'b1;
          end else if (flags.sclFall) begin
            if (flags.byteDone) begin
              cmd.finishReply = 1'b1;
              nextState       = ST_SKIP;
            end else begin
              cmd.stepReply = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busState <= ST_IDLE;
    else       busState <= nextState;
  end

endmodule

// File: rtl/smb_alert_top.sv
module smb_alert_top
  import smb_alert_pkg::*;
#(
  parameter int          TIMEOUT_TICKS = 30,
  parameter int          OT_COUNT      = 3,
  parameter logic [6:0]  ADDR_LOW      = 7'h2F,
  parameter logic [6:0]  ADDR_OPEN     = 7'h2F,
  parameter logic [6:0]  ADDR_HIGH     = 7'h2E,
  parameter logic [6:0]  ARA_ADDR      = 7'h0C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic                errFlag,
  input  logic [1:0]          addrSel,
  input  logic                tick,
  input  logic                maskClr,
  input  logic [OT_COUNT-1:0] overTempIn,
  output logic                alertN,
  output logic                sdaPullDown,
  output logic                busReset,
  output logic [6:0]          ownAddr,
  output logic [OT_COUNT-1:0] overTempN
);

  strobeT   cmdBus;
  busFlagsT flagBus;
  busStateT busState;
  logic     maskOn;

  smb_alert_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .flags    (flagBus),
    .cmd      (cmdBus),
    .busState (busState)
  );

  smb_alert_dp #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .OT_COUNT      (OT_COUNT),
    .ADDR_LOW      (ADDR_LOW),
    .ADDR_OPEN     (ADDR_OPEN),
    .ADDR_HIGH     (ADDR_HIGH),
    .ARA_ADDR      (ARA_ADDR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .errFlag    (errFlag),
    .addrSel    (addrSel),
    .tick       (tick),
    .maskClr    (maskClr),
    .overTempIn (overTempIn),
    .cmd        (cmdBus),
    .flags      (flagBus),
    .sdaDrive   (sdaPullDown),
    .alertN     (alertN),
    .maskOn     (maskOn),
    .busReset   (busReset),
    .ownAddr    (ownAddr),
    .overTempN  (overTempN)
  );

endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk
  import smb_alert_pkg::*;
#(
  parameter int OT_COUNT = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                errFlag,
  input logic                alertN,
  input logic                sdaPullDown,
  input logic                busReset,
  input logic                maskOn,
  input logic                replyDone,
  input busStateT            busState,
  input logic [OT_COUNT-1:0] overTempIn,
  input logic [OT_COUNT-1:0] overTempN
);

  // R1
  alert_needs_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    !alertN |-> errFlag);

  // R5
  mask_set_by_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(maskOn) |-> $past(replyDone));

  // R7
  pull_only_when_answering_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullDown |-> (busState == ST_ACK || busState == ST_REPLY));

  // R9
  timeout_releases_sda_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !sdaPullDown);

  // R8
  overtemp_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(overTempIn)) |=> $stable(overTempN));

endmodule

bind smb_alert_top smb_alert_chk #(.OT_COUNT(OT_COUNT)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .errFlag     (errFlag),
  .alertN      (alertN),
  .sdaPullDown (sdaPullDown),
  .busReset    (busReset),
  .maskOn      (maskOn),
  .replyDone   (cmdBus.finishReply),
  .busState    (busState),
  .overTempIn  (overTempIn),
  .overTempN   (overTempN)
);

// File: tb/sim_smb_alert_top.sv
module sim_smb_alert_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostScl = 1'b1;
  logic       hostSda = 1'b1;
  logic       compSda = 1'b1;
  logic       errFlag = 1'b0;
  logic [1:0] addrSel = 2'b00;
  logic       tick = 1'b0;
  logic       maskClr = 1'b0;
  logic [2:0] overTempIn = 3'b000;
  logic       sdaLine;
  logic       alertN, sdaPullDown, busReset;
  logic [6:0] ownAddr;
  logic [2:0] overTempN;

  int  nChecks = 0;
  int  nFail = 0;
  int  pulseCnt = 0;
  bit  pdSeen = 1'b0;
  bit  finished = 1'b0;
  bit  maskM = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = hostSda & compSda & ~sdaPullDown;

  smb_alert_top u0 (
    .clk(clk), .rstN(rstN), .sclIn(hostScl), .sdaIn(sdaLine),
    .errFlag(errFlag), .addrSel(addrSel), .tick(tick), .maskClr(maskClr),
    .overTempIn(overTempIn), .alertN(alertN), .sdaPullDown(sdaPullDown),
    .busReset(busReset), .ownAddr(ownAddr), .overTempN(overTempN)
  );

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  always @(negedge clk) begin
    if (sdaPullDown) pdSeen = 1'b1;
    if (busReset) pulseCnt = pulseCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] expAddr(input logic [1:0] sel);
    return (sel == 2'b10) ? 7'h2E : 7'h2F;
  endfunction

  function automatic logic [7:0] wiredByte(input logic [7:0] mine, input logic [7:0] other);
    logic [7:0] r;
    logic lostL;
    lostL = 1'b0;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      if (!lostL) begin
        r[i] = mine[i] & other[i];
        if (mine[i] && !other[i]) lostL = 1'b1;
      end else begin
        r[i] = other[i];
      end
    end
    return r;
  endfunction

  task automatic busStart();
    hostSda = 1'b1; cyc(4);
    hostScl = 1'b1; cyc(4);
    hostSda = 1'b0; cyc(4);
    hostScl = 1'b0; cyc(4);
  endtask

  task automatic busStop();
    hostSda = 1'b0; cyc(4);
    hostScl = 1'b1; cyc(4);
    hostSda = 1'b1; cyc(4);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    hostSda = b; cyc(4);
    hostScl = 1'b1; cyc(2);
    seen = sdaLine; cyc(2);
    hostScl = 1'b0;
  endtask

  // optional stray bits and repeated start, then one byte, ack slot, reply
  task automatic doTxn(input int stray, input logic [7:0] addrByte, input logic [7:0] comp,
                       output bit acked, output logic [7:0] got);
    logic s;
    got = 8'h00;
    pdSeen = 1'b0;
    busStart();
    if (stray > 0) begin
      for (int i = 0; i < stray; i++) clockBit(1'b1, s);
      busStart();
    end
    for (int i = 7; i >= 0; i--) clockBit(addrByte[i], s);
    clockBit(1'b1, s);
    acked = !s;
    if (acked) begin
      for (int i = 7; i >= 0; i--) begin
        compSda = comp[i];
        clockBit(1'b1, s);
        got[i] = s;
      end
      compSda = 1'b1;
      clockBit(1'b1, s);
    end
    busStop();
    cyc(6);
  endtask

  task automatic clearMask();
    maskClr = 1'b1; cyc(1);
    maskClr = 1'b0; cyc(1);
    maskM = 1'b0;
  endtask

  initial begin
    bit acked;
    logic [7:0] got, mine, expLine;
    logic s;
    void'($urandom(32'd20240611));
    cyc(5);
    rstN = 1'b1;
    cyc(2);

    // reset state
    chk(alertN == 1'b1, "R1 reset alertN", alertN, 1);
    chk(sdaPullDown == 1'b0, "R7 reset pull-down", sdaPullDown, 0);
    chk(overTempN == 3'b111, "R8 reset overtemp", overTempN, 3'b111);

    // over-temperature latency
    overTempIn = 3'b101; cyc(1);
    chk(overTempN == 3'b010, "R8 one-cycle follow", overTempN, 3'b010);

    // address decode, every select code
    for (int k = 0; k < 4; k++) begin
      addrSel = 2'(k); cyc(1);
      chk(ownAddr == expAddr(2'(k)), "R6 address decode", ownAddr, expAddr(2'(k)));
    end

    // plain alert response, no competitor
    errFlag = 1'b1; addrSel = 2'b00; cyc(1);
    chk(alertN == 1'b0, "R1 alert asserted", alertN, 0);
    pulseCnt = 0;
    doTxn(0, 8'h19, 8'hFF, acked, got);
    chk(acked, "R2 ack of alert response", acked, 1);
    chk(got == 8'h5E, "R3 reply byte", got, 8'h5E);
    chk(alertN == 1'b1, "R5 alert released after clean reply", alertN, 1);
    chk(overTempN == 3'b010, "R8 outputs untouched by reply", overTempN, 3'b010);
    maskM = 1'b1;

    // masked: no answer
    doTxn(0, 8'h19, 8'hFF, acked, got);
    chk(!acked && !pdSeen, "R7 no answer while masked", pdSeen, 0);

    // mask clear re-enables
    clearMask();
    chk(alertN == 1'b0, "R5 mask clear reasserts alert", alertN, 0);

    // arbitration loss against a lower address
    addrSel = 2'b10; cyc(1);
    doTxn(0, 8'h19, 8'h5A, acked, got);
    chk(acked, "R2 ack before arbitration", acked, 1);
    chk(got == 8'h5A, "R4 stop driving after loss", got, 8'h5A);
    chk(alertN == 1'b0, "R4 mask unchanged after loss", alertN, 0);

    // repeated start after stray bits
    doTxn(3, 8'h19, 8'hFF, acked, got);
    chk(acked && got == 8'h5C, "R10 reply after repeated start", got, 8'h5C);
    chk(alertN == 1'b1, "R10 mask set after repeated start reply", alertN, 1);
    maskM = 1'b1;
    chk(pulseCnt == 0, "R9 no timeout while bus active", pulseCnt, 0);

    // idle timeout in the middle of a byte
    clearMask();
    addrSel = 2'b00;
    busStart();
    for (int i = 7; i >= 5; i--) clockBit(1'b0, s);
    pulseCnt = 0;
    cyc(180);
    chk(pulseCnt == 1, "R9 single reset pulse", pulseCnt, 1);
    pdSeen = 1'b0;
    begin
      logic [7:0] araB;
      araB = 8'h19;
      for (int i = 4; i >= 0; i--) clockBit(araB[i], s);
    end
    clockBit(1'b1, s);
    chk(s == 1'b1 && !pdSeen, "R9 dropped transaction not acked", s, 1);
    busStop();
    cyc(6);

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [7:0] aB, cB;
      bit expAck;
      addrSel = 2'($urandom % 4);
      errFlag = ($urandom % 4) != 0;
      if ($urandom % 3 == 0) clearMask();
      aB = ($urandom % 4 != 0) ? 8'h19 : 8'($urandom % 256);
      cB = ($urandom % 3 == 0) ? 8'($urandom % 256) : 8'hFF;
      overTempIn = 3'($urandom % 8);
      cyc(1);
      expAck = (aB == 8'h19) && errFlag && !maskM;
      pulseCnt = 0;
      doTxn(0, aB, cB, acked, got);
      chk(acked == expAck, "R2 random ack decision", acked, expAck);
      if (!expAck) chk(!pdSeen, "R7 random silence", pdSeen, 0);
      if (acked) begin
        mine = {expAddr(addrSel), 1'b0};
        expLine = wiredByte(mine, cB);
        chk(got == expLine, "R4 random wired reply", got, expLine);
        if ((mine & ~cB) == 8'h00) maskM = 1'b1;
      end
      chk(alertN == !(errFlag && !maskM), "R1 random alert level", alertN, !(errFlag && !maskM));
      chk(overTempN == ~overTempIn, "R8 random overtemp", overTempN, ~overTempIn);
      chk(pulseCnt == 0, "R9 random no spurious reset", pulseCnt, 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule